// File: doc/BRIEF.md
# In-Order Rename Stall Interlock

This block makes an out-of-order core behave as an in-order issuer when that is wanted. It keeps, for every hardware thread, a pointer to the instruction that thread renamed most recently. When the thread asks to dispatch another instruction, the block looks up whether that earlier instruction has all of its register sources ready. If it does not, the new instruction is held at rename.

The pointer is kept lazily. It is never cleared when its instruction retires or is freed. Instead, at the moment a hold would be raised, a wrap-aware range test checks whether the recorded reorder-buffer slot still lies inside the thread's live window (head through head plus count minus one). A pointer found outside that window raises no hold and drops to null.

The readiness lookup is external and combinational: the block presents a pointer and a queue tag, and gets back one ready bit per thread. The hold and dispatch-grant outputs are combinational. The pointer update is registered.

Top module: `inorder_rename_interlock`

## Requirements
- R1: A single mode input governs all threads. While it is low, no thread is ever held, and a recorded pointer is neither checked nor cleared.
- R2: Reset empties every thread's record, so no hold is raised until that thread renames again. A rename on a thread replaces that thread's record with the new instruction, whatever kind of instruction it is.
- R3: The cycle after a rename, `lookup_ptr` for that thread carries the load/store queue slot with `lookup_is_lsq`=1 if the instruction allocated one. Otherwise it carries the reorder-buffer slot with `lookup_is_lsq`=0.
- R4: A hold is raised when all of these are true: dispatch is requested, the mode is on, the record is non-null, the lookup reports not ready, and the recorded slot is inside the live window.
- R5: When the lookup reports ready, no hold is raised. The record is kept and is not checked for staleness.
- R6: A record is stale whenever the thread's reorder-buffer count is zero.
- R7: The window test adds the buffer depth (16) to a slot below head, then accepts it if it lies between head and head+count-1 inclusive. This accepts wrapped windows, a full buffer (count 16) and both window ends.
- R8: A stale record raises no hold and becomes null at the next clock edge, so it causes no later hold.
- R9: `disp_go` is dispatch request without hold for each thread. A held thread drops out, and the other threads still go.
- R10: A rename and an evaluation in the same cycle on one thread evaluate the old record. A rename in the same cycle as a stale clear leaves the new record in place.
- R11: Each thread's record, window and hold are independent of the other threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inorder_en | input | 1 | In-order mode for the whole core |
| rob_head | input | 8 | Per-thread reorder-buffer head slot, 4 bits each |
| rob_count | input | 10 | Per-thread occupied entries, 5 bits each (0..16) |
| ren_valid | input | 2 | Per-thread rename event |
| ren_rob_slot | input | 8 | Reorder-buffer slot of the renamed instruction |
| ren_has_lsq | input | 2 | Renamed instruction also allocated a load/store queue slot |
| ren_lsq_slot | input | 8 | Load/store queue slot of the renamed instruction |
| disp_req | input | 2 | Per-thread dispatch candidate |
| lookup_ptr | output | 8 | Recorded slot presented to the readiness lookup |
| lookup_is_lsq | output | 2 | 1: lookup_ptr is a load/store queue slot |
| lookup_ready | input | 2 | Lookup answer: recorded instruction has all sources ready |
| stall | output | 2 | Per-thread hold at rename |
| disp_go | output | 2 | Per-thread dispatch grant after holds |

## Verification
`stall` and `disp_go` depend combinationally on the current head, count, request and ready inputs, and on the stored record. They are due in the same cycle as their stimulus. A rename or a stale clear changes the record only at the next rising edge, so its effect on `lookup_ptr` and on holds is due one cycle later. The bench drives every input just after the falling edge and samples 2 ns later, before the next rising edge. So each same-cycle result is read against the record written at the previous edge, and each record update is checked one cycle after its cause.

// File: rtl/iorl_pkg.sv
package iorl_pkg;
  localparam int ROB_DEPTH = 16;
  localparam int LSQ_DEPTH = 16;
  localparam int RIDX_W    = $clog2(ROB_DEPTH);
  localparam int LIDX_W    = $clog2(LSQ_DEPTH);
  localparam int PTR_W     = (RIDX_W > LIDX_W) ? RIDX_W : LIDX_W;
  localparam int CNT_W     = RIDX_W + 1;
  localparam int WIN_W     = RIDX_W + 1;

  typedef struct packed {
    logic              live;
    logic              is_lsq;
    logic [RIDX_W-1:0] rob_slot;
    logic [PTR_W-1:0]  ptr;
  } lastop_t;
endpackage

// File: rtl/lastop_record.sv
module lastop_record
  import iorl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_v,
  input  logic [RIDX_W-1:0] ren_rob,
  input  logic              ren_mem,
  input  logic [LIDX_W-1:0] ren_lsq,
  input  logic              stale_clr,
  output lastop_t           rec_q
);
  lastop_t rec_d;
  logic    rec_en;

  always_comb begin
    rec_en = ren_v | stale_clr;
    rec_d  = '0;
    if (ren_v) begin
      rec_d.live     = 1'b1;
      rec_d.is_lsq   = ren_mem;
      rec_d.rob_slot = ren_rob;
      rec_d.ptr      = ren_mem ? PTR_W'(ren_lsq) : PTR_W'(ren_rob);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end

  assert_rename_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_v |=> (rec_q.live && rec_q.rob_slot == $past(ren_rob)));
  assert_tag_follows_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ren_v |=> (rec_q.is_lsq == $past(ren_mem)));
  assert_stale_nulled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_clr && !ren_v) |=> !rec_q.live);
  assert_lazy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stale_clr && !ren_v) |=> $stable(rec_q));
endmodule

// File: rtl/rob_window_check.sv
module rob_window_check
  import iorl_pkg::*;
(
  input  logic [RIDX_W-1:0] slot,
  input  logic [RIDX_W-1:0] head,
  input  logic [CNT_W-1:0]  count,
  output logic              in_win
);
  logic [WIN_W-1:0] slot_ext;
  logic [WIN_W-1:0] head_ext;
  logic [WIN_W-1:0] upper;

  always_comb begin
    head_ext = {1'b0, head};
    slot_ext = {1'b0, slot};
    if (slot < head) slot_ext = slot_ext + WIN_W'(ROB_DEPTH);
    upper    = head_ext + WIN_W'(count) - WIN_W'(1);
    in_win   = (count != '0) && (slot_ext >= head_ext) && (slot_ext <= upper);
  end

  always_comb begin
    if (count == '0) assert_empty_rob_invalid_R6: assert (!in_win);
    if (in_win && count == CNT_W'(ROB_DEPTH))
      assert_full_rob_window_R7: assert (slot_ext >= head_ext);
  end
endmodule

// File: rtl/stall_decide.sv
module stall_decide (
  input  logic mode_en,
  input  logic req,
  input  logic rec_live,
  input  logic ready,
  input  logic in_win,
  output logic hold,
  output logic stale_clr
);
  logic pending;

  always_comb begin
    pending   = mode_en & req & rec_live & ~ready;
    hold      = pending & in_win;
    stale_clr = pending & ~in_win;
  end

  always_comb begin
    assert_hold_or_clear_R8: assert (!(hold && stale_clr));
  end
endmodule

// File: rtl/inorder_rename_interlock.sv
module inorder_rename_interlock
  import iorl_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inorder_en,
  input  logic [NUM_THREADS*RIDX_W-1:0] rob_head,
  input  logic [NUM_THREADS*CNT_W-1:0]  rob_count,
  input  logic [NUM_THREADS-1:0]        ren_valid,
  input  logic [NUM_THREADS*RIDX_W-1:0] ren_rob_slot,
  input  logic [NUM_THREADS-1:0]        ren_has_lsq,
  input  logic [NUM_THREADS*LIDX_W-1:0] ren_lsq_slot,
  input  logic [NUM_THREADS-1:0]        disp_req,
  output logic [NUM_THREADS*PTR_W-1:0]  lookup_ptr,
  output logic [NUM_THREADS-1:0]        lookup_is_lsq,
  input  logic [NUM_THREADS-1:0]        lookup_ready,
  output logic [NUM_THREADS-1:0]        stall,
  output logic [NUM_THREADS-1:0]        disp_go
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    lastop_t rec;
    logic    in_win;
    logic    clr;

    lastop_record u_rec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ren_v     (ren_valid[t]),
      .ren_rob   (ren_rob_slot[t*RIDX_W +: RIDX_W]),
      .ren_mem   (ren_has_lsq[t]),
      .ren_lsq   (ren_lsq_slot[t*LIDX_W +: LIDX_W]),
      .stale_clr (clr),
      .rec_q     (rec)
    );

    rob_window_check u_win (
      .slot   (rec.rob_slot),
      .head   (rob_head[t*RIDX_W +: RIDX_W]),
      .count  (rob_count[t*CNT_W +: CNT_W]),
      .in_win (in_win)
    );

    stall_decide u_dec (
      .mode_en   (inorder_en),
      .req       (disp_req[t]),
      .rec_live  (rec.live),
      .ready     (lookup_ready[t]),
      .in_win    (in_win),
      .hold      (stall[t]),
      .stale_clr (clr)
    );

    assign lookup_ptr[t*PTR_W +: PTR_W] = rec.ptr;
    assign lookup_is_lsq[t]             = rec.is_lsq;
    assign disp_go[t]                   = disp_req[t] & ~stall[t];

    assert_held_thread_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stall[t] |-> !disp_go[t]);
    assert_mode_off_no_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !inorder_en |-> !stall[t]);
    assert_null_record_no_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rec.live |-> !stall[t]);
  end
endmodule

// File: tb/inorder_rename_interlock_tb.sv
module inorder_rename_interlock_tb;
  import iorl_pkg::*;
  localparam int NT = 2;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   inorder_en;
  logic [NT*RIDX_W-1:0]   rob_head;
  logic [NT*CNT_W-1:0]    rob_count;
  logic [NT-1:0]          ren_valid;
  logic [NT*RIDX_W-1:0]   ren_rob_slot;
  logic [NT-1:0]          ren_has_lsq;
  logic [NT*LIDX_W-1:0]   ren_lsq_slot;
  logic [NT-1:0]          disp_req;
  logic [NT*PTR_W-1:0]    lookup_ptr;
  logic [NT-1:0]          lookup_is_lsq;
  logic [NT-1:0]          lookup_ready;
  logic [NT-1:0]          stall;
  logic [NT-1:0]          disp_go;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  inorder_rename_interlock #(.NUM_THREADS(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .inorder_en(inorder_en),
    .rob_head(rob_head), .rob_count(rob_count),
    .ren_valid(ren_valid), .ren_rob_slot(ren_rob_slot),
    .ren_has_lsq(ren_has_lsq), .ren_lsq_slot(ren_lsq_slot),
    .disp_req(disp_req), .lookup_ptr(lookup_ptr),
    .lookup_is_lsq(lookup_is_lsq), .lookup_ready(lookup_ready),
    .stall(stall), .disp_go(disp_go)
  );

  // {ren, mem, rob[4], lsq[4], disp, head[4], cnt[5], ready, exp_stall} for thread 0
  localparam logic [21:0] VEC [18] = '{
    {1'b1,1'b0,4'd2, 4'd0,1'b1,4'd0, 5'd4, 1'b0,1'b0}, // R10 old null record
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd0, 5'd4, 1'b0,1'b1}, // R4
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd0, 5'd4, 1'b1,1'b0}, // R5
    {1'b1,1'b1,4'd3, 4'd9,1'b1,4'd0, 5'd4, 1'b0,1'b1}, // R10 old rob2
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd0, 5'd4, 1'b0,1'b1}, // R2
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd14,5'd6, 1'b0,1'b1}, // R7 wrap, top end
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd14,5'd5, 1'b0,1'b0}, // R7 one past end
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd0, 5'd8, 1'b0,1'b0}, // R8 nulled
    {1'b1,1'b0,4'd10,4'd0,1'b0,4'd0, 5'd8, 1'b0,1'b0},
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd12,5'd4, 1'b0,1'b0}, // R7 below head
    {1'b1,1'b0,4'd10,4'd0,1'b0,4'd0, 5'd0, 1'b0,1'b0},
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd8, 5'd3, 1'b0,1'b1}, // R7 upper end
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd11,5'd16,1'b0,1'b1}, // R7 full buffer
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd10,5'd0, 1'b0,1'b0}, // R6
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd10,5'd1, 1'b0,1'b0}, // R8
    {1'b1,1'b0,4'd15,4'd0,1'b0,4'd0, 5'd0, 1'b0,1'b0},
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd15,5'd1, 1'b0,1'b1}, // R7 lower end
    {1'b0,1'b0,4'd0, 4'd0,1'b1,4'd0, 5'd15,1'b0,1'b0}  // R7 slot 15 outside 0..14
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = '0; ren_rob_slot = '0; ren_has_lsq = '0; ren_lsq_slot = '0;
    disp_req = '0; lookup_ready = '1; rob_head = '0; rob_count = '0;
  endtask

  task automatic thr(input int t, input logic rv, input logic mem, input logic [3:0] rob,
                     input logic [3:0] lsq, input logic dq, input logic [3:0] hd,
                     input logic [4:0] cn, input logic rdy);
    ren_valid[t] = rv; ren_has_lsq[t] = mem;
    ren_rob_slot[t*4 +: 4] = rob; ren_lsq_slot[t*4 +: 4] = lsq;
    disp_req[t] = dq; rob_head[t*4 +: 4] = hd; rob_count[t*5 +: 5] = cn;
    lookup_ready[t] = rdy;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; inorder_en = 1'b1; idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state: records empty, nothing held
    @(negedge clk); idle(); thr(0,0,0,0,0,1,0,4,0); thr(1,0,0,0,0,1,0,4,0); #2;
    chk("R2 reset stall", stall, 2'b00);
    chk("R9 reset disp_go", disp_go, 2'b11);

    for (int i = 0; i < 18; i++) begin
      @(negedge clk); idle();
      thr(0, VEC[i][21], VEC[i][20], VEC[i][19:16], VEC[i][15:12], VEC[i][11],
          VEC[i][10:7], VEC[i][6:2], VEC[i][1]);
      thr(1, 0, 0, 0, 0, 1, 0, 4, 0);
      #2;
      chk($sformatf("R4/R7 vector %0d stall0", i), stall[0], VEC[i][0]);
      chk($sformatf("R9 vector %0d go0", i), disp_go[0], VEC[i][11] & ~VEC[i][0]);
      chk($sformatf("R11 vector %0d thread1", i), {stall[1], disp_go[1]}, 2'b01);
    end

    // R3 lookup pointer and tag
    @(negedge clk); idle(); thr(0,1,1,4'd4,4'd11,0,0,0,1);
    @(negedge clk); idle(); #2;
    chk("R3 lsq ptr", {lookup_is_lsq[0], lookup_ptr[3:0]}, {1'b1, 4'd11});
    thr(0,1,0,4'd6,4'd2,0,0,0,1);
    @(negedge clk); idle(); #2;
    chk("R3 rob ptr", {lookup_is_lsq[0], lookup_ptr[3:0]}, {1'b0, 4'd6});

    // R1 mode off: no hold, no clear of a stale-looking record
    inorder_en = 1'b0; thr(0,0,0,0,0,1,0,8,0); #2;
    chk("R1 off no hold", stall[0], 1'b0);
    @(negedge clk); idle(); thr(0,0,0,0,0,1,0,0,0); #2;
    chk("R1 off empty rob", stall[0], 1'b0);
    @(negedge clk); idle(); inorder_en = 1'b1; thr(0,0,0,0,0,1,0,8,0); #2;
    chk("R1 record kept while off", stall[0], 1'b1);

    // R9/R11 two threads
    @(negedge clk); idle(); thr(1,1,0,4'd1,0,0,0,0,1);
    @(negedge clk); idle(); thr(0,0,0,0,0,1,0,8,0); thr(1,0,0,0,0,1,0,4,1); #2;
    chk("R9 one held", {stall, disp_go}, {2'b01, 2'b10});
    thr(1,0,0,0,0,1,0,4,0); #1;
    chk("R11 both held", {stall, disp_go}, {2'b11, 2'b00});

    // R10 rename wins over stale clear in the same cycle
    @(negedge clk); idle(); thr(0,1,0,4'd9,0,1,4'd8,5'd2,0); #2;
    chk("R10 stale no hold", stall[0], 1'b0);
    @(negedge clk); idle(); thr(0,0,0,0,0,1,4'd8,5'd2,0); #2;
    chk("R10 new record kept", stall[0], 1'b1);

    // R2 reset empties a live record
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; idle(); thr(0,0,0,0,0,1,4'd8,5'd2,0); #2;
    chk("R2 reset clears record", stall[0], 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule